// File: doc/BRIEF.md
# Command Completion Monitor with Timeout

This block watches the status lines of a processor control port after a command has been issued. It decides whether that command finished within a cycle budget. Each request selects one of three completion rules:

- **command:** wait for the acknowledge bit.
- **run:** wait until the processor is neither busy nor running.
- **step:** wait until the processor is neither busy nor stepping.

Every rule has its own budget, which is reset to a default and can be rewritten at any time. A request copies the budget for its rule when it is accepted.

When the wait ends, the block reports a single verdict code and the number of cycles that elapsed.

- If the request asked for a data check, the returned word is compared with an expected word under a don't-care mask.
- The command-error and memory-error flags are compared with what the request expected.
- Error classes are ranked above the data comparison.

A wait that runs out of budget reports a timeout and raises a one-cycle reset request for the surrounding logic.

Top module: `cmd_wait_monitor`

## Requirements
- R1: While rst_ni is low, and after it is released, busy_o, done_o, timeout_o and rst_req_o are 0, verdict_o is 0 and cycles_o is 0.
- R2: A request is accepted on the clock edge where start_i is 1. The wait counter holds 1 in the cycle after that edge. All status inputs are registered once. If the completion condition is first captured at the k-th edge after the accepting edge (k=0 is the accepting edge itself) and k is no greater than the budget, done_o pulses one cycle after edge k+1 and cycles_o = k+1. The default budgets are 50 (command), 100 (step) and 5000 (run).
- R3: Mode code 0 (command) completes when ack_i is 1.
- R4: Mode code 1 (step) completes when busy_i and step_i are both 0. The value of run_i does not matter in this mode.
- R5: Mode code 2 (run) completes when busy_i and run_i are both 0. Mode code 3 is not accepted.
- R6: If the condition has not been captured by edge budget, the block responds one edge later. It pulses timeout_o and rst_req_o for one cycle, sets verdict_o to 9 and sets cycles_o to budget+1. done_o and timeout_o are never high together.
- R7: With chk_i set and no error class active, verdict_o is 1 when ((rdata XOR exp_data) AND NOT mask) is zero, and 2 otherwise. A mask bit of 1 marks that bit as don't-care.
- R8: The command-error class is evaluated first. It is active when cmd_err_i is seen or exp_cerr_i was requested. It gives verdict 3 when the error is seen but not expected, 4 when it is expected and seen, and 5 when it is expected but missed. It overrides the memory-error class and the data check.
- R9: The memory-error class is evaluated second and overrides the data check. It gives verdict 6 when the error is seen but not expected, 7 when it is expected and seen, and 8 when it is expected but missed.
- R10: A write with cfg_we_i replaces the budget for mode code cfg_sel_i. A wait already in progress keeps the budget it copied when it started.
- R11: start_i is ignored while busy_o is 1. It does not restart the counter and does not change the mode.
- R12: A completed wait with no data check and no error class active gives verdict 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| mode_i | input | 2 | Completion rule: 0 command, 1 step, 2 run |
| chk_i | input | 1 | Request a data comparison |
| exp_data_i | input | 16 | Expected returned word |
| mask_i | input | 16 | Don't-care bits (1 = ignore) |
| exp_cerr_i | input | 1 | A command error is expected |
| exp_merr_i | input | 1 | A memory error is expected |
| cfg_we_i | input | 1 | Budget write strobe |
| cfg_sel_i | input | 2 | Mode code whose budget is written |
| cfg_val_i | input | 16 | New budget value |
| ack_i | input | 1 | Command acknowledge status |
| busy_i | input | 1 | Command busy status |
| run_i | input | 1 | Processor running status |
| step_i | input | 1 | Processor stepping status |
| cmd_err_i | input | 1 | Command error status |
| mem_err_i | input | 1 | Memory error status |
| rdata_i | input | 16 | Returned data word |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle pulse: the wait completed |
| timeout_o | output | 1 | One-cycle pulse: the wait failed |
| rst_req_o | output | 1 | One-cycle reset request on failure |
| verdict_o | output | 4 | Result code, held until the next result |
| cycles_o | output | 17 | Elapsed cycle count, held |

## Verification
Status changes reach the result only through one input register and one result register. A condition captured at edge k is therefore reported after edge k+1. The bench drives each completion pattern on the falling edge before a chosen edge k. It then polls the outputs on each falling edge and expects the first pulse at exactly poll k+2, with cycles_o equal to k+1. A pulse that comes early or late counts as a failure. Timeouts follow the same rule: the pulse is due at poll budget+2, with cycles_o equal to budget+1. The boundary pairs k=budget and k=budget+1 fix the exact edge where completion gives way to timeout.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
  typedef enum logic [1:0] {
    M_CMD  = 2'd0,
    M_STEP = 2'd1,
    M_RUN  = 2'd2
  } wait_mode_e;

  typedef enum logic [3:0] {
    V_OK         = 4'd0,
    V_DATA_OK    = 4'd1,
    V_DATA_BAD   = 4'd2,
    V_CERR_UNEXP = 4'd3,
    V_CERR_SEEN  = 4'd4,
    V_CERR_MISS  = 4'd5,
    V_MERR_UNEXP = 4'd6,
    V_MERR_SEEN  = 4'd7,
    V_MERR_MISS  = 4'd8,
    V_TIMEOUT    = 4'd9
  } verdict_e;

  typedef struct packed {
    logic ack;
    logic busy;
    logic run;
    logic step;
    logic cerr;
    logic merr;
  } stat_t;
endpackage

// File: rtl/cwm_status_reg.sv
module cwm_status_reg import cwm_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stat_t         stat_i,
  input  logic [DW-1:0] rdata_i,
  output stat_t         stat_o,
  output logic [DW-1:0] rdata_o
);
  // idle status after reset: busy/run/step high so no rule completes spuriously
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o  <= '{ack: 1'b0, busy: 1'b1, run: 1'b1, step: 1'b1, cerr: 1'b0, merr: 1'b0};
      rdata_o <= '0;
    end else begin
      stat_o  <= stat_i;
      rdata_o <= rdata_i;
    end
  end
endmodule

// File: rtl/cwm_budget_regs.sv
module cwm_budget_regs #(
  parameter int TW      = 16,
  parameter int TO_CMD  = 50,
  parameter int TO_STEP = 100,
  parameter int TO_RUN  = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [TW-1:0] val_i,
  input  logic [1:0]    rd_sel_i,
  output logic [TW-1:0] budget_o
);
  localparam int NMODE = 3;
  localparam logic [TW-1:0] DEF [NMODE] = '{TW'(TO_CMD), TW'(TO_STEP), TW'(TO_RUN)};

  logic [TW-1:0] regs_q [NMODE];

  for (genvar g = 0; g < NMODE; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_q[g] <= DEF[g];
      else if (we_i && sel_i == 2'(g))     regs_q[g] <= val_i;
    end
  end

  always_comb begin
    budget_o = regs_q[0];
    for (int i = 1; i < NMODE; i++)
      if (rd_sel_i == 2'(i)) budget_o = regs_q[i];
  end

  assert_cfg_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i != 2'd3) |=> (regs_q[$past(sel_i)] == $past(val_i)));
endmodule

// File: rtl/cwm_verdict.sv
module cwm_verdict import cwm_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          cerr_i,
  input  logic          merr_i,
  input  logic          exp_cerr_i,
  input  logic          exp_merr_i,
  input  logic          chk_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] exp_i,
  input  logic [DW-1:0] mask_i,
  output verdict_e      verdict_o
);
  logic data_match;
  assign data_match = ((rdata_i ^ exp_i) & ~mask_i) == '0;

  // fixed precedence: command error, memory error, data
  always_comb begin
    if (cerr_i || exp_cerr_i)
      verdict_o = !cerr_i ? V_CERR_MISS : (exp_cerr_i ? V_CERR_SEEN : V_CERR_UNEXP);
    else if (merr_i || exp_merr_i)
      verdict_o = !merr_i ? V_MERR_MISS : (exp_merr_i ? V_MERR_SEEN : V_MERR_UNEXP);
    else if (chk_i)
      verdict_o = data_match ? V_DATA_OK : V_DATA_BAD;
    else
      verdict_o = V_OK;
  end
endmodule

// File: rtl/cmd_wait_monitor.sv
module cmd_wait_monitor import cwm_pkg::*; #(
  parameter int DW      = 16,
  parameter int TW      = 16,
  parameter int TO_CMD  = 50,
  parameter int TO_STEP = 100,
  parameter int TO_RUN  = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic          chk_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [DW-1:0] mask_i,
  input  logic          exp_cerr_i,
  input  logic          exp_merr_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [TW-1:0] cfg_val_i,
  input  logic          ack_i,
  input  logic          busy_i,
  input  logic          run_i,
  input  logic          step_i,
  input  logic          cmd_err_i,
  input  logic          mem_err_i,
  input  logic [DW-1:0] rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic          rst_req_o,
  output logic [3:0]    verdict_o,
  output logic [TW:0]   cycles_o
);
  localparam int CW = TW + 1;

  stat_t         stat_d, stat_q;
  logic [DW-1:0] rdata_q;
  logic [TW-1:0] budget_sel;
  verdict_e      verdict_d;

  logic          busy_q, done_q, to_q;
  logic [CW-1:0] cnt_q, cycles_q;
  logic [TW-1:0] budget_q;
  wait_mode_e    mode_q;
  logic          chk_q, ecerr_q, emerr_q;
  logic [DW-1:0] exp_q, mask_q;
  verdict_e      verdict_q;
  logic          accept, cond;

  assign stat_d = '{ack: ack_i, busy: busy_i, run: run_i, step: step_i,
                    cerr: cmd_err_i, merr: mem_err_i};

  cwm_status_reg #(.DW(DW)) u_stat (
    .clk_i, .rst_ni, .stat_i(stat_d), .rdata_i,
    .stat_o(stat_q), .rdata_o(rdata_q)
  );

  cwm_budget_regs #(.TW(TW), .TO_CMD(TO_CMD), .TO_STEP(TO_STEP), .TO_RUN(TO_RUN)) u_budget (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_sel_i), .val_i(cfg_val_i),
    .rd_sel_i(mode_i), .budget_o(budget_sel)
  );

  cwm_verdict #(.DW(DW)) u_verdict (
    .cerr_i(stat_q.cerr), .merr_i(stat_q.merr),
    .exp_cerr_i(ecerr_q), .exp_merr_i(emerr_q), .chk_i(chk_q),
    .rdata_i(rdata_q), .exp_i(exp_q), .mask_i(mask_q),
    .verdict_o(verdict_d)
  );

  assign accept = start_i && !busy_q && mode_i != 2'd3;

  always_comb begin
    unique case (mode_q)
      M_CMD:   cond = stat_q.ack;
      M_STEP:  cond = !stat_q.busy && !stat_q.step;
      M_RUN:   cond = !stat_q.busy && !stat_q.run;
      default: cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      to_q      <= 1'b0;
      cnt_q     <= '0;
      cycles_q  <= '0;
      budget_q  <= '0;
      mode_q    <= M_CMD;
      chk_q     <= 1'b0;
      ecerr_q   <= 1'b0;
      emerr_q   <= 1'b0;
      exp_q     <= '0;
      mask_q    <= '0;
      verdict_q <= V_OK;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        cnt_q    <= CW'(1);
        budget_q <= budget_sel;
        mode_q   <= wait_mode_e'(mode_i);
        chk_q    <= chk_i;
        ecerr_q  <= exp_cerr_i;
        emerr_q  <= exp_merr_i;
        exp_q    <= exp_data_i;
        mask_q   <= mask_i;
      end else if (busy_q) begin
        if (cond) begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          cycles_q  <= cnt_q;
          verdict_q <= verdict_d;
        end else if (cnt_q > {1'b0, budget_q}) begin
          busy_q    <= 1'b0;
          to_q      <= 1'b1;
          cycles_q  <= cnt_q;
          verdict_q <= V_TIMEOUT;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign timeout_o = to_q;
  assign rst_req_o = to_q;
  assign verdict_o = verdict_q;
  assign cycles_o  = cycles_q;

  assert_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && to_q));
  assert_timeout_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |-> (cycles_q == {1'b0, budget_q} + 1'b1) && (verdict_q == V_TIMEOUT));
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= {1'b0, budget_q} + 1'b1));
  assert_first_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (cnt_q == CW'(1)));
  assert_result_after_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q || to_q) |-> ($past(busy_q) && !busy_q));
  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (mode_q == $past(mode_q)) && !$rose(busy_q));
endmodule

// File: tb/tb_cmd_wait_monitor.sv
`timescale 1ns/1ps
module tb_cmd_wait_monitor;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, chk_i = 0, exp_cerr_i = 0, exp_merr_i = 0, cfg_we_i = 0;
  logic [1:0] mode_i = 0, cfg_sel_i = 0;
  logic [15:0] exp_data_i = 0, mask_i = 0, cfg_val_i = 0, rdata_i = 0;
  logic ack_i = 0, busy_i = 1, run_i = 1, step_i = 1, cmd_err_i = 0, mem_err_i = 0;
  logic busy_o, done_o, timeout_o, rst_req_o;
  logic [3:0] verdict_o;
  logic [16:0] cycles_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmd_wait_monitor dut (
    .clk_i(clk), .rst_ni, .start_i, .mode_i, .chk_i, .exp_data_i, .mask_i,
    .exp_cerr_i, .exp_merr_i, .cfg_we_i, .cfg_sel_i, .cfg_val_i,
    .ack_i, .busy_i, .run_i, .step_i, .cmd_err_i, .mem_err_i, .rdata_i,
    .busy_o, .done_o, .timeout_o, .rst_req_o, .verdict_o, .cycles_o
  );

  typedef struct packed {
    logic [1:0]         md;
    logic signed [31:0] k;     // edge where completion is first captured, -1 never
    logic               chk;
    logic [15:0]        ex, mk, rd;
    logic               ce, me, ece, eme;
    logic [3:0]         ev;
    logic [31:0]        ec;
    logic [3:0]         rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{2'd0,  3, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,0, 4'd0,  4,    4'd3},  // R3 R12
    '{2'd0,  0, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,0, 4'd0,  1,    4'd2},  // R2 earliest
    '{2'd0,  5, 1, 16'h1234, 16'h0000, 16'h1234, 0,0,0,0, 4'd1,  6,    4'd7},  // R7 match
    '{2'd0,  2, 1, 16'h1234, 16'h0000, 16'h1235, 0,0,0,0, 4'd2,  3,    4'd7},  // R7 lsb differs
    '{2'd0,  1, 1, 16'h12F4, 16'h00F0, 16'h1204, 0,0,0,0, 4'd1,  2,    4'd7},  // R7 masked nibble
    '{2'd0,  1, 1, 16'hFFFF, 16'h7FFF, 16'h0000, 0,0,0,0, 4'd2,  2,    4'd7},  // R7 unmasked msb
    '{2'd0,  2, 0, 16'h0000, 16'h0000, 16'h0000, 1,1,0,0, 4'd3,  3,    4'd8},  // R8 over merr
    '{2'd0,  2, 1, 16'h0001, 16'h0000, 16'h0000, 1,0,1,0, 4'd4,  3,    4'd8},  // R8 seen
    '{2'd0,  2, 0, 16'h0000, 16'h0000, 16'h0000, 0,1,1,0, 4'd5,  3,    4'd8},  // R8 missed
    '{2'd0,  4, 1, 16'h0001, 16'h0000, 16'h0000, 0,1,0,0, 4'd6,  5,    4'd9},  // R9 over data
    '{2'd0,  4, 0, 16'h0000, 16'h0000, 16'h0000, 0,1,0,1, 4'd7,  5,    4'd9},  // R9 seen
    '{2'd0,  4, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,1, 4'd8,  5,    4'd9},  // R9 missed
    '{2'd1,  7, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,0, 4'd0,  8,    4'd4},  // R4 run stays high
    '{2'd2, 10, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,0, 4'd0,  11,   4'd5},  // R5
    '{2'd0, 50, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,0, 4'd0,  51,   4'd2},  // R2 at budget
    '{2'd0, 51, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,0, 4'd9,  51,   4'd6},  // R6 one late
    '{2'd1,100, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,0, 4'd0,  101,  4'd4},  // R4 at budget
    '{2'd1, -1, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,0, 4'd9,  101,  4'd6},  // R6 step
    '{2'd2, -1, 0, 16'h0000, 16'h0000, 16'h0000, 0,0,0,0, 4'd9,  5001, 4'd6}   // R6 run default
  };

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  task automatic set_idle();
    ack_i = 0; busy_i = 1; run_i = 1; step_i = 1;
    cmd_err_i = 0; mem_err_i = 0; rdata_i = 0;
  endtask

  task automatic set_done(input vec_t v);
    case (v.md)
      2'd0: ack_i = 1;
      2'd1: begin busy_i = 0; step_i = 0; end
      default: begin busy_i = 0; run_i = 0; end
    endcase
    cmd_err_i = v.ce; mem_err_i = v.me; rdata_i = v.rd;
  endtask

  // polls once per falling edge; first pulse expected at poll ec+1
  task automatic wait_result(input vec_t v, input string rq);
    int seen_at = -1;
    for (int j = 1; j <= 6000; j++) begin
      @(negedge clk);
      start_i = 0;
      if (done_o || timeout_o) begin seen_at = j; break; end
      if (j == v.k) set_done(v);
    end
    check(seen_at == int'(v.ec) + 1, rq, "pulse poll", seen_at, int'(v.ec) + 1);
    check(cycles_o == v.ec[16:0], rq, "cycles_o", cycles_o, v.ec);
    check(verdict_o == v.ev, rq, "verdict_o", verdict_o, v.ev);
    check(timeout_o == (v.ev == 4'd9) && rst_req_o == (v.ev == 4'd9), rq,
          "timeout/rst_req", {timeout_o, rst_req_o}, (v.ev == 4'd9) ? 3 : 0);
    check(done_o == (v.ev != 4'd9), rq, "done_o", done_o, v.ev != 4'd9);
    set_idle();
    @(negedge clk);
    check(!done_o && !timeout_o && !busy_o, rq, "pulse width", {done_o, timeout_o}, 0);
  endtask

  task automatic run_vec(input vec_t v, input string rq);
    @(negedge clk);
    set_idle();
    start_i = 1; mode_i = v.md; chk_i = v.chk; exp_data_i = v.ex; mask_i = v.mk;
    exp_cerr_i = v.ece; exp_merr_i = v.eme;
    if (v.k == 0) set_done(v);
    wait_result(v, rq);
  endtask

  task automatic write_budget(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_val_i = val;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  initial begin
    vec_t v;
    #1;
    // R1 during reset
    check(!busy_o && !done_o && !timeout_o && !rst_req_o && verdict_o == 0 && cycles_o == 0,
          "R1", "outputs in reset", {busy_o, done_o, timeout_o, verdict_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    check(!busy_o && !done_o && !timeout_o && !rst_req_o && verdict_o == 0 && cycles_o == 0,
          "R1", "outputs after reset", {busy_o, done_o, timeout_o, verdict_o}, 0);

    for (int i = 0; i < NV; i++)
      run_vec(VEC[i], $sformatf("R%0d", VEC[i].rq));

    // R10 and R11: budget copied at start, second start ignored mid-wait
    write_budget(2'd0, 16'd5);
    @(negedge clk);
    set_idle();
    start_i = 1; mode_i = 2'd0; chk_i = 0; exp_cerr_i = 0; exp_merr_i = 0;
    @(negedge clk);                       // poll 1
    start_i = 0;
    cfg_we_i = 1; cfg_sel_i = 2'd0; cfg_val_i = 16'd2;
    check(busy_o, "R11", "busy after start", busy_o, 1);
    @(negedge clk);                       // poll 2
    cfg_we_i = 0;
    start_i = 1; mode_i = 2'd2;           // must be ignored
    @(negedge clk);                       // poll 3
    start_i = 0;
    check(!timeout_o && busy_o, "R10", "mid-wait write did not shorten wait", timeout_o, 0);
    @(negedge clk);                       // poll 4: drive before edge 4
    ack_i = 1;
    @(negedge clk);
    check(!done_o, "R11", "no early pulse", done_o, 0);
    @(negedge clk);                       // poll 6
    check(done_o && cycles_o == 17'd5, "R11", "cycles with ignored restart", cycles_o, 5);
    check(verdict_o == 4'd0, "R10", "verdict copied-budget wait", verdict_o, 0);
    set_idle();

    // R10: new budget 2 applies to the next request
    v = '{2'd0, 2, 0, 16'h0, 16'h0, 16'h0, 0,0,0,0, 4'd0, 3, 4'd10};
    run_vec(v, "R10");
    v = '{2'd0, 3, 0, 16'h0, 16'h0, 16'h0, 0,0,0,0, 4'd9, 3, 4'd10};
    run_vec(v, "R10");

    // R5: mode code 3 not accepted
    @(negedge clk);
    start_i = 1; mode_i = 2'd3;
    @(negedge clk);
    start_i = 0;
    check(!busy_o, "R5", "mode 3 rejected", busy_o, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule